// File: doc/BRIEF.md
# Debug Entry Controller with Debug Control/Status and Resume-PC Registers

This block decides, once per cycle, whether a hart must stop normal execution and enter debug mode. Four sources can request this: a breakpoint instruction, a trigger hit, an external halt request, and the end of a single-stepped instruction. The end of a stepped instruction is reported either as a normal retire or as a trap. When several sources are active in the same cycle, one combinational arbiter chooses the cause with the highest priority. It raises a single-cycle entry pulse. At the next clock edge it records the cause, the privilege level and the resume address.

The block holds the debug control/status register (CSR address 0x7b0) and the resume program counter (CSR address 0x7b1). It decodes their fields into control outputs for the rest of the hart: whether a step is armed, whether interrupts are allowed while stepping, the privilege level to return to, and inhibit signals that freeze the counters and the hart-local timers. A resume pulse from the pipeline takes the hart out of debug mode.

Top module: `dbg_ctrl_csr`

## Requirements
- R1: When more than one entry source is active in the same cycle, the recorded cause is the one with the highest priority. The order is trigger hit (code 2), then breakpoint instruction (code 1), then external halt request (code 3), then step completion (code 4). The cause is read in bits 8:6 of the control/status register and on `cause_o`.
- R2: A breakpoint instruction requests entry only when its enable bit is set for the privilege level it runs at. Bit 15 covers machine level (3), bit 13 covers supervisor level (1) and bit 12 covers user level (0). In all other cases the breakpoint event is ignored.
- R3: Step completion (`step_retire_i` or `step_trap_i`) requests entry only while the step bit (bit 2) is set and the hart is outside debug mode. `step_active_o` equals the step bit while the hart is outside debug mode and is 0 inside it.
- R4: On entry, bits 1:0 capture `cur_prv_i`. A CSR write sets bits 1:0 to the written level, except that the reserved value 2 becomes 3, and a written 1 becomes 0 when supervisor level is not supported. `exit_prv_o` always shows bits 1:0.
- R5: On entry, the resume-PC register captures `cur_pc_i`. It can be read and written at CSR address 0x7b1, and `dpc_o` shows its contents.
- R6: `stop_count_o` is 1 when bit 10 is set and either the hart is in debug mode or a breakpoint instruction is causing entry in that cycle. `stop_time_o` is 1 when bit 9 is set and the hart is in debug mode.
- R7: Bits 31:28 of the control/status register always read 4. The cause field ignores writes. Bits 15, 13, 12, 11, 10, 9 and 2 are writable. Bit 11 drives `stepie_o`. All other bits read 0.
- R8: While the hart is in debug mode, no entry source raises `enter_dbg_o` or changes the cause. A `resume_i` pulse in debug mode clears `dbg_mode_o` at the next edge.
- R9: After reset the hart is outside debug mode, the privilege field reads 3, every other writable field and the cause read 0, and the resume PC reads 0.
- R10: `enter_dbg_o` is a combinational pulse in the cycle the qualified source is present. `dbg_mode_o`, the cause, the privilege field and the resume PC take their new values at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_brk_i | input | 1 | Breakpoint instruction executed this cycle |
| ev_trig_i | input | 1 | Trigger hit this cycle |
| ev_halt_i | input | 1 | External halt request |
| step_retire_i | input | 1 | Stepped instruction retired |
| step_trap_i | input | 1 | Stepped instruction raised an exception |
| cur_prv_i | input | 2 | Current privilege level |
| cur_pc_i | input | XLEN | Address to resume at if entry happens now |
| resume_i | input | 1 | Leave debug mode |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| enter_dbg_o | output | 1 | Entry pulse |
| dbg_mode_o | output | 1 | Hart is in debug mode |
| cause_o | output | 3 | Recorded entry cause |
| exit_prv_o | output | 2 | Privilege level used on resume |
| dpc_o | output | XLEN | Resume program counter |
| step_active_o | output | 1 | Single step armed |
| stepie_o | output | 1 | Interrupts enabled while stepping |
| stop_count_o | output | 1 | Counter inhibit |
| stop_time_o | output | 1 | Timer inhibit |

## Verification
The bench applies combinations of entry sources at the same time. An arbiter with the wrong order would record, for example, the halt code where the trigger code is expected. It issues breakpoints at privilege levels whose enable bit is clear, and a step completion while the step bit is clear; a faulty gate would enter debug mode spuriously. It sends new requests while the hart is already in debug mode, which exposes a design that re-enters and overwrites the cause. It also checks the breakpoint-only counter inhibit in the entry cycle, writes of the reserved privilege value, and writes to the read-only version and cause fields.

// File: rtl/dbg_pkg.sv
`timescale 1ns/1ps
package dbg_pkg;
  localparam logic [11:0] ADDR_CTL = 12'h7b0;
  localparam logic [11:0] ADDR_RPC = 12'h7b1;
  localparam logic [3:0]  DBG_VER  = 4'd4;

  localparam logic [2:0] CS_NONE  = 3'd0;
  localparam logic [2:0] CS_BRK   = 3'd1;
  localparam logic [2:0] CS_TRIG  = 3'd2;
  localparam logic [2:0] CS_HALT  = 3'd3;
  localparam logic [2:0] CS_STEP  = 3'd4;

  localparam logic [1:0] LVL_U = 2'd0;
  localparam logic [1:0] LVL_S = 2'd1;
  localparam logic [1:0] LVL_M = 2'd3;

  // bit positions that the hart's privileged logic decodes
  localparam int B_BRKM = 15;
  localparam int B_BRKS = 13;
  localparam int B_BRKU = 12;
  localparam int B_SIE  = 11;
  localparam int B_SCNT = 10;
  localparam int B_STIM = 9;
  localparam int B_STEP = 2;

  typedef struct packed {
    logic       brk_m;
    logic       brk_s;
    logic       brk_u;
    logic       step_ie;
    logic       stop_cnt;
    logic       stop_tim;
    logic       step;
    logic [2:0] cause;
    logic [1:0] prv;
  } ctl_t;

  // map a requested privilege level onto one the hart supports
  function automatic logic [1:0] legal_prv(input logic [1:0] p, input bit has_s);
    logic [1:0] r;
    r = p;
    if (p == 2'd2) r = LVL_M;
    else if (p == LVL_S && !has_s) r = LVL_U;
    return r;
  endfunction

  // fixed-priority choice among simultaneous entry sources
  function automatic logic [2:0] rank_cause(input logic trig, input logic brk,
                                            input logic halt, input logic step);
    logic [2:0] c;
    if (trig)      c = CS_TRIG;
    else if (brk)  c = CS_BRK;
    else if (halt) c = CS_HALT;
    else if (step) c = CS_STEP;
    else           c = CS_NONE;
    return c;
  endfunction

  function automatic logic [31:0] pack_ctl(input ctl_t c);
    logic [31:0] w;
    w = '0;
    w[31:28]  = DBG_VER;
    w[B_BRKM] = c.brk_m;
    w[B_BRKS] = c.brk_s;
    w[B_BRKU] = c.brk_u;
    w[B_SIE]  = c.step_ie;
    w[B_SCNT] = c.stop_cnt;
    w[B_STIM] = c.stop_tim;
    w[8:6]    = c.cause;
    w[B_STEP] = c.step;
    w[1:0]    = c.prv;
    return w;
  endfunction
endpackage

// File: rtl/dbg_entry_arb.sv
`timescale 1ns/1ps
module dbg_entry_arb
  import dbg_pkg::*;
(
  input  logic       in_dbg_i,
  input  logic       ev_brk_i,
  input  logic [2:0] brk_en_i,     // {machine, supervisor, user}
  input  logic [1:0] prv_i,
  input  logic       ev_trig_i,
  input  logic       ev_halt_i,
  input  logic       step_en_i,
  input  logic       step_retire_i,
  input  logic       step_trap_i,
  output logic       brk_q_o,
  output logic       step_q_o,
  output logic       enter_o,
  output logic [2:0] cause_o
);
  logic brk_allowed;
  logic trig_q, halt_q;

  always_comb begin
    unique case (prv_i)
      LVL_M:   brk_allowed = brk_en_i[2];
      LVL_S:   brk_allowed = brk_en_i[1];
      LVL_U:   brk_allowed = brk_en_i[0];
      default: brk_allowed = 1'b0;
    endcase
  end

  assign brk_q_o  = ev_brk_i & brk_allowed & ~in_dbg_i;
  assign step_q_o = step_en_i & (step_retire_i | step_trap_i) & ~in_dbg_i;
  assign trig_q   = ev_trig_i & ~in_dbg_i;
  assign halt_q   = ev_halt_i & ~in_dbg_i;

  assign cause_o = rank_cause(trig_q, brk_q_o, halt_q, step_q_o);
  assign enter_o = (cause_o != CS_NONE);
endmodule

// File: rtl/dbg_ctl_regs.sv
`timescale 1ns/1ps
module dbg_ctl_regs
  import dbg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_S     = 1'b1,
  parameter bit STEPIE_WR = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_i,
  input  logic [2:0]      cause_i,
  input  logic [1:0]      cur_prv_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic            resume_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output ctl_t            ctl_o,
  output logic            in_dbg_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [XLEN-1:0] rdata_o
);
  logic wr_ctl, wr_rpc;
  assign wr_ctl = csr_we_i && (csr_addr_i == ADDR_CTL);
  assign wr_rpc = csr_we_i && (csr_addr_i == ADDR_RPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_o    <= '0;
      ctl_o.prv <= LVL_M;
      in_dbg_o <= 1'b0;
      dpc_o    <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_o.brk_m    <= csr_wdata_i[B_BRKM];
        ctl_o.brk_s    <= csr_wdata_i[B_BRKS];
        ctl_o.brk_u    <= csr_wdata_i[B_BRKU];
        ctl_o.step_ie  <= STEPIE_WR ? csr_wdata_i[B_SIE] : 1'b0;
        ctl_o.stop_cnt <= csr_wdata_i[B_SCNT];
        ctl_o.stop_tim <= csr_wdata_i[B_STIM];
        ctl_o.step     <= csr_wdata_i[B_STEP];
        ctl_o.prv      <= legal_prv(csr_wdata_i[1:0], HAS_S);
      end
      if (wr_rpc) dpc_o <= csr_wdata_i;
      if (enter_i) begin
        in_dbg_o    <= 1'b1;
        ctl_o.cause <= cause_i;
        ctl_o.prv   <= legal_prv(cur_prv_i, HAS_S);
        dpc_o       <= cur_pc_i;
      end else if (resume_i && in_dbg_o) begin
        in_dbg_o <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (csr_addr_i == ADDR_CTL)      rdata_o[31:0] = pack_ctl(ctl_o);
    else if (csr_addr_i == ADDR_RPC) rdata_o = dpc_o;
  end
endmodule

// File: rtl/dbg_ctrl_csr.sv
`timescale 1ns/1ps
module dbg_ctrl_csr
  import dbg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_S     = 1'b1,
  parameter bit STEPIE_WR = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_brk_i,
  input  logic            ev_trig_i,
  input  logic            ev_halt_i,
  input  logic            step_retire_i,
  input  logic            step_trap_i,
  input  logic [1:0]      cur_prv_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic            resume_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            enter_dbg_o,
  output logic            dbg_mode_o,
  output logic [2:0]      cause_o,
  output logic [1:0]      exit_prv_o,
  output logic [XLEN-1:0] dpc_o,
  output logic            step_active_o,
  output logic            stepie_o,
  output logic            stop_count_o,
  output logic            stop_time_o
);
  ctl_t       ctl;
  logic       in_dbg;
  logic       brk_q, step_q;
  logic [2:0] next_cause;

  dbg_entry_arb u_arb (
    .in_dbg_i      (in_dbg),
    .ev_brk_i      (ev_brk_i),
    .brk_en_i      ({ctl.brk_m, ctl.brk_s, ctl.brk_u}),
    .prv_i         (cur_prv_i),
    .ev_trig_i     (ev_trig_i),
    .ev_halt_i     (ev_halt_i),
    .step_en_i     (ctl.step),
    .step_retire_i (step_retire_i),
    .step_trap_i   (step_trap_i),
    .brk_q_o       (brk_q),
    .step_q_o      (step_q),
    .enter_o       (enter_dbg_o),
    .cause_o       (next_cause)
  );

  dbg_ctl_regs #(.XLEN(XLEN), .HAS_S(HAS_S), .STEPIE_WR(STEPIE_WR)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_i     (enter_dbg_o),
    .cause_i     (next_cause),
    .cur_prv_i   (cur_prv_i),
    .cur_pc_i    (cur_pc_i),
    .resume_i    (resume_i),
    .csr_we_i    (csr_we_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .ctl_o       (ctl),
    .in_dbg_o    (in_dbg),
    .dpc_o       (dpc_o),
    .rdata_o     (csr_rdata_o)
  );

  assign dbg_mode_o    = in_dbg;
  assign cause_o       = ctl.cause;
  assign exit_prv_o    = ctl.prv;
  assign step_active_o = ctl.step & ~in_dbg;
  assign stepie_o      = ctl.step_ie;
  assign stop_count_o  = ctl.stop_cnt & (in_dbg | brk_q);
  assign stop_time_o   = ctl.stop_tim & in_dbg;
endmodule

// File: rtl/dbg_ctrl_csr_chk.sv
`timescale 1ns/1ps
module dbg_ctrl_csr_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_trig_i,
  input logic            resume_i,
  input logic [XLEN-1:0] cur_pc_i,
  input logic [11:0]     csr_addr_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            enter_dbg_o,
  input logic            dbg_mode_o,
  input logic [2:0]      cause_o,
  input logic [1:0]      exit_prv_o,
  input logic [XLEN-1:0] dpc_o,
  input logic            stop_time_o,
  input logic            step_q
);
  AST_TRIG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    enter_dbg_o && ev_trig_i |=> cause_o == 3'd2); // R1
  AST_STEP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |-> enter_dbg_o); // R3
  AST_PRV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    exit_prv_o != 2'b10); // R4
  AST_RPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_dbg_o |=> dpc_o == $past(cur_pc_i)); // R5
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stop_time_o |-> dbg_mode_o); // R6
  AST_VERSION_RO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_addr_i == 12'h7b0 |-> csr_rdata_o[31:28] == 4'd4); // R7
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    enter_dbg_o |-> !dbg_mode_o); // R8
  AST_RESUME_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode_o && resume_i |=> !dbg_mode_o); // R8
  AST_ENTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_dbg_o |=> dbg_mode_o); // R10
  AST_MODE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_mode_o) |-> $past(enter_dbg_o)); // R10
endmodule

bind dbg_ctrl_csr dbg_ctrl_csr_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_trig_i   (ev_trig_i),
  .resume_i    (resume_i),
  .cur_pc_i    (cur_pc_i),
  .csr_addr_i  (csr_addr_i),
  .csr_rdata_o (csr_rdata_o),
  .enter_dbg_o (enter_dbg_o),
  .dbg_mode_o  (dbg_mode_o),
  .cause_o     (cause_o),
  .exit_prv_o  (exit_prv_o),
  .dpc_o       (dpc_o),
  .stop_time_o (stop_time_o),
  .step_q      (step_q)
);

// File: tb/dbg_ctrl_csr_test.sv
`timescale 1ns/1ps
module dbg_ctrl_csr_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, ev_brk, ev_trig, ev_halt, st_ret, st_trap, resume, we;
  logic [1:0]  prv;
  logic [31:0] pc, addr, wdata, rdata, dpc, rd;
  logic        enter, dmode, sact, sie, scnt, stim;
  logic [2:0]  cause;
  logic [1:0]  xprv;
  int n_chk = 0, n_fail = 0;
  logic [9:0] v;

  dbg_ctrl_csr uut (
    .clk(clk), .rst_n(rst_n), .ev_brk_i(ev_brk), .ev_trig_i(ev_trig), .ev_halt_i(ev_halt),
    .step_retire_i(st_ret), .step_trap_i(st_trap), .cur_prv_i(prv), .cur_pc_i(pc),
    .resume_i(resume), .csr_we_i(we), .csr_addr_i(addr[11:0]), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .enter_dbg_o(enter), .dbg_mode_o(dmode), .cause_o(cause),
    .exit_prv_o(xprv), .dpc_o(dpc), .step_active_o(sact), .stepie_o(sie),
    .stop_count_o(scnt), .stop_time_o(stim)
  );

  // {trig, brk, halt, step, prv[1:0], expect_entry, expect_cause[2:0]}
  localparam logic [9:0] VEC [10] = '{
    10'b1000_11_1_010, 10'b0100_00_1_001, 10'b0010_01_1_011, 10'b0001_11_1_100,
    10'b1100_01_1_010, 10'b0110_11_1_001, 10'b0011_00_1_011, 10'b1111_11_1_010,
    10'b0000_01_0_000, 10'b0101_00_1_001
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic clr_ev;
    ev_brk = 0; ev_trig = 0; ev_halt = 0; st_ret = 0; st_trap = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic rdc(input logic [31:0] a);
    addr = a;
    #1;
    rd = rdata;
  endtask

  task automatic leave;
    if (dmode) begin
      resume = 1;
      tick();
      resume = 0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; clr_ev(); resume = 0; we = 0; addr = 0; wdata = 0; prv = 3; pc = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    // R9 reset state
    chk("R9 mode", {31'b0, dmode}, 0);
    chk("R9 prv", {30'b0, xprv}, 3);
    rdc(32'h7b0); chk("R9 ctl", rd, 32'h4000_0003);
    rdc(32'h7b1); chk("R9 rpc", rd, 0);
    // R7 writable set and read-only fields
    wr(32'h7b0, 32'hFFFF_FFFF);
    rdc(32'h7b0); chk("R7 ctl all ones", rd, 32'h4000_BE07);
    chk("R7 stepie", {31'b0, sie}, 1);
    chk("R3 step armed", {31'b0, sact}, 1);
    // table: all breakpoint enables and step armed
    wr(32'h7b0, 32'h0000_B007);
    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      {ev_trig, ev_brk, ev_halt, st_ret} = v[9:6];
      prv = v[5:4];
      pc = 32'h1000 + 32'(i) * 4;
      #1;
      chk($sformatf("R1 entry pulse vec%0d", i), {31'b0, enter}, {31'b0, v[3]});
      chk($sformatf("R10 mode not yet vec%0d", i), {31'b0, dmode}, 0);
      tick();
      clr_ev();
      chk($sformatf("R10 mode vec%0d", i), {31'b0, dmode}, {31'b0, v[3]});
      if (v[3]) begin
        chk($sformatf("R1 cause vec%0d", i), {29'b0, cause}, {29'b0, v[2:0]});
        chk($sformatf("R4 prv capture vec%0d", i), {30'b0, xprv}, {30'b0, v[5:4]});
        chk($sformatf("R5 rpc capture vec%0d", i), dpc, pc);
        chk($sformatf("R3 step idle in debug vec%0d", i), {31'b0, sact}, 0);
      end
      leave();
    end
    // R2 gating: user only
    wr(32'h7b0, 32'h0000_1003);
    ev_brk = 1; prv = 3; #1;
    chk("R2 brk m disabled", {31'b0, enter}, 0);
    prv = 0; #1;
    chk("R2 brk u enabled", {31'b0, enter}, 1);
    tick(); clr_ev();
    chk("R2 cause", {29'b0, cause}, 1);
    leave();
    wr(32'h7b0, 32'h0000_2003);
    ev_brk = 1; prv = 0; #1;
    chk("R2 brk u disabled", {31'b0, enter}, 0);
    prv = 1; #1;
    chk("R2 brk s enabled", {31'b0, enter}, 1);
    tick(); clr_ev(); leave();
    // R3 step disarmed then trap completion
    wr(32'h7b0, 32'h0000_0003);
    st_ret = 1; #1;
    chk("R3 step off ignored", {31'b0, enter}, 0);
    tick(); clr_ev();
    chk("R3 step off mode", {31'b0, dmode}, 0);
    wr(32'h7b0, 32'h0000_0007);
    st_trap = 1; #1;
    chk("R3 trap enters", {31'b0, enter}, 1);
    tick(); clr_ev();
    chk("R3 trap cause", {29'b0, cause}, 4);
    leave();
    // R8 no re-entry
    wr(32'h7b0, 32'h0000_0003);
    ev_halt = 1; tick(); clr_ev();
    chk("R8 in debug", {31'b0, dmode}, 1);
    ev_trig = 1; ev_halt = 1; #1;
    chk("R8 no pulse", {31'b0, enter}, 0);
    tick(); clr_ev();
    chk("R8 cause kept", {29'b0, cause}, 3);
    resume = 1; tick(); resume = 0;
    chk("R8 resume", {31'b0, dmode}, 0);
    // R4 privilege writes
    wr(32'h7b0, 32'h0000_0002); chk("R4 reserved to M", {30'b0, xprv}, 3);
    wr(32'h7b0, 32'h0000_0001); chk("R4 write S", {30'b0, xprv}, 1);
    wr(32'h7b0, 32'h0000_0000); chk("R4 write U", {30'b0, xprv}, 0);
    // R6 inhibits
    wr(32'h7b0, 32'h0000_8603);
    chk("R6 count idle", {31'b0, scnt}, 0);
    chk("R6 time idle", {31'b0, stim}, 0);
    ev_brk = 1; prv = 3; #1;
    chk("R6 count on brk entry", {31'b0, scnt}, 1);
    chk("R6 time on brk entry", {31'b0, stim}, 0);
    tick(); clr_ev();
    chk("R6 count in debug", {31'b0, scnt}, 1);
    chk("R6 time in debug", {31'b0, stim}, 1);
    leave();
    ev_halt = 1; #1;
    chk("R6 count on halt entry", {31'b0, scnt}, 0);
    tick(); clr_ev(); leave();
    // R5 write/read resume PC
    wr(32'h7b1, 32'h1234_5678);
    rdc(32'h7b1); chk("R5 rpc rw", rd, 32'h1234_5678);
    chk("R5 dpc port", dpc, 32'h1234_5678);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule